// File: doc/BRIEF.md
# Packetized Stream Length Tracker

This block sits behind a streaming audio port and receives payload packets of 1 to 32 bytes. Each byte arrives as one beat with a valid strobe; the first beat of a packet carries a start strobe and the packet length, and the final beat carries an end strobe. While the tracker is idle, a packet of exactly 32 bytes is taken as a stream header. Two size fields inside that header give the total stream length, and the tracker then counts the following packets until that total has been reached.

Every byte the tracker accepts goes into an internal 2048-byte circular buffer. The consumer drains this buffer through a simple read port. The header bytes are stored like any other data and count toward the running total. The packet that arrives after the total has been reached closes the stream. It is discarded, and the tracker goes back to waiting for a header. When the buffer is full, further writes are dropped, and a sticky flag records the loss.

Top module: `stream_len_tracker`

## Requirements
- R1: After reset the tracker is waiting (`streaming`=0), `total_size` and `accum_count` are 0, the buffer is empty and not full, and `buf_overflow` is 0.
- R2: While waiting, a packet of length 32 is a header. After its end beat, `streaming` is 1 and `accum_count` is 32, because the header's own bytes count. Its bytes are written to the buffer.
- R3: The header's total is (header byte 5 << 7) + (header byte 6 & 0x7F) + 8. Byte 0 is the beat that carries the start strobe. Byte 5 is used in full, 8 bits wide, so the largest total is 32775.
- R4: While waiting, a packet whose length is not 32 leaves `streaming` at 0 and the counters at 0. Its bytes are still written to the buffer.
- R5: While streaming with `accum_count` < `total_size`, a packet's bytes are written to the buffer. After its end beat, `accum_count` has grown by the packet length.
- R6: While streaming with `accum_count` >= `total_size`, the next packet is not written to the buffer. After its end beat, `streaming`, `total_size` and `accum_count` are all 0.
- R7: The buffer is first-in first-out. A read request on a non-empty buffer presents the oldest byte on `rd_data`, with `rd_valid` high, one cycle later.
- R8: The write and read indices are 11 bits wide and wrap modulo 2048. Data written after the indices wrap reads back intact and in order.
- R9: `buf_full` is 1 when 2048 bytes are held. A write while the buffer is full is dropped and sets `buf_overflow`, which stays at 1 until reset, even after reads.
- R10: A read request on an empty buffer is ignored: `rd_valid` stays 0 and nothing changes.
- R11: While streaming below the total, a 32-byte packet is ordinary data. It does not reload `total_size`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_valid | input | 1 | A byte beat is present |
| pkt_first | input | 1 | Start strobe, marks byte 0 of a packet |
| pkt_last | input | 1 | End strobe, marks the final byte of a packet |
| pkt_len | input | 6 | Packet length 1..32, sampled with the start strobe |
| pkt_data | input | 8 | Payload byte |
| rd_en | input | 1 | Consumer read request |
| rd_data | output | 8 | Byte read from the buffer |
| rd_valid | output | 1 | `rd_data` holds a byte from the previous read request |
| buf_full | output | 1 | The buffer holds 2048 bytes |
| buf_empty | output | 1 | The buffer holds no bytes |
| buf_overflow | output | 1 | Sticky flag: a write was dropped because the buffer was full |
| streaming | output | 1 | 1 after a header, 0 while waiting |
| total_size | output | 16 | Decoded stream total |
| accum_count | output | 16 | Bytes counted so far in the stream |

## Verification
Tracker state (`streaming`, `total_size`, `accum_count`) takes the end beat at one rising edge and shows the result right after it. The bench drives beats on falling edges and checks the state at the falling edge that follows the end beat. A buffer write takes effect at the same edge as its beat, so `buf_empty` and `buf_full` are checked at the next falling edge. A read issued at one falling edge is checked for data and `rd_valid` at the next falling edge, one register later. The bench keeps its own queue of the bytes that should have been stored and compares every byte drained against it.

// File: rtl/strk_pkg.sv
package strk_pkg;

    // Tracker phase: waiting for a header, or counting a stream.
    typedef enum logic {
        ST_WAIT   = 1'b0,
        ST_STREAM = 1'b1
    } strk_state_e;

    // Treatment of the packet in flight, fixed at its start beat.
    typedef enum logic [1:0] {
        PK_PLAIN = 2'd0,   // idle, not a header: store only
        PK_HDR   = 2'd1,   // idle, header: store, decode size
        PK_DATA  = 2'd2,   // streaming below total: store, count
        PK_CLOSE = 2'd3    // streaming at/over total: discard, return idle
    } pkt_act_e;

endpackage

// File: rtl/strk_ctrl.sv
module strk_ctrl
    import strk_pkg::*;
#(
    parameter int LEN_W    = 6,
    parameter int DATA_W   = 8,
    parameter int CNT_W    = 16,
    parameter int HDR_LEN  = 32,
    parameter int HI_IDX   = 5,
    parameter int LO_IDX   = 6,
    parameter int FIELD_W  = 7,
    parameter int SIZE_OFS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_first,
    input  logic              in_last,
    input  logic [LEN_W-1:0]  in_len,
    input  logic [DATA_W-1:0] in_data,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data,
    output logic              streaming,
    output logic [CNT_W-1:0]  total,
    output logic [CNT_W-1:0]  accum
);

    localparam logic [LEN_W-1:0] HDR_LEN_V = LEN_W'(HDR_LEN);
    localparam logic [LEN_W-1:0] HI_IDX_V  = LEN_W'(HI_IDX);
    localparam logic [LEN_W-1:0] LO_IDX_V  = LEN_W'(LO_IDX);

    typedef struct packed {
        strk_state_e         state;
        pkt_act_e            act;
        logic                in_pkt;
        logic [LEN_W-1:0]    idx;
        logic [LEN_W-1:0]    len;
        logic [DATA_W-1:0]   hi;
        logic [FIELD_W-1:0]  lo;
        logic [CNT_W-1:0]    total;
        logic [CNT_W-1:0]    acc;
    } ctrl_regs_t;

    ctrl_regs_t q, d;

    logic             beat_ok;
    pkt_act_e         start_act;
    pkt_act_e         cur_act;
    logic [LEN_W-1:0] cur_idx;
    logic [LEN_W-1:0] cur_len;

    always_comb begin
        // classification of a packet that starts on this beat
        if (q.state == ST_WAIT) begin
            start_act = (in_len == HDR_LEN_V) ? PK_HDR : PK_PLAIN;
        end else begin
            start_act = (q.acc < q.total) ? PK_DATA : PK_CLOSE;
        end

        beat_ok = in_valid && (in_first || q.in_pkt);
        cur_act = in_first ? start_act : q.act;
        cur_idx = in_first ? '0 : q.idx;
        cur_len = in_first ? in_len : q.len;

        d       = q;
        wr_en   = 1'b0;
        wr_data = in_data;

        if (beat_ok) begin
            wr_en    = (cur_act != PK_CLOSE);
            d.act    = cur_act;
            d.len    = cur_len;
            d.idx    = cur_idx + LEN_W'(1);
            d.in_pkt = !in_last;

            if (cur_act == PK_HDR) begin
                if (cur_idx == HI_IDX_V) d.hi = in_data;
                if (cur_idx == LO_IDX_V) d.lo = in_data[FIELD_W-1:0];
            end

            if (in_last) begin
                unique case (cur_act)
                    PK_HDR: begin
                        d.state = ST_STREAM;
                        d.total = CNT_W'({q.hi, {FIELD_W{1'b0}}})
                                + CNT_W'(q.lo) + CNT_W'(SIZE_OFS);
                        d.acc   = CNT_W'(cur_len);
                    end
                    PK_DATA: begin
                        d.acc = q.acc + CNT_W'(cur_len);
                    end
                    PK_CLOSE: begin
                        d.state = ST_WAIT;
                        d.total = '0;
                        d.acc   = '0;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign streaming = (q.state == ST_STREAM);
    assign total     = q.total;
    assign accum     = q.acc;

    // R2
    hdr_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_ok && in_last && cur_act == PK_HDR) |=> (streaming && accum == CNT_W'(HDR_LEN)));

    // R4
    plain_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_ok && in_last && cur_act == PK_PLAIN) |=> (!streaming && accum == '0));

    // R6
    close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_ok && in_last && cur_act == PK_CLOSE) |=> (!streaming && accum == '0 && total == '0));

    // R11
    total_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_ok && cur_act == PK_DATA) |=> $stable(total));

endmodule

// File: rtl/strk_ring.sv
module strk_ring #(
    parameter int AW     = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              full,
    output logic              empty,
    output logic              overflow
);

    localparam int DEPTH = 1 << AW;

    typedef struct packed {
        logic [AW:0]       wptr;
        logic [AW:0]       rptr;
        logic [DATA_W-1:0] rdata;
        logic              rvalid;
        logic              ovf;
    } ring_regs_t;

    ring_regs_t q, d;
    logic [DATA_W-1:0] mem [DEPTH];
    logic do_wr, do_rd;

    always_comb begin
        empty = (q.wptr == q.rptr);
        full  = (q.wptr[AW] != q.rptr[AW]) && (q.wptr[AW-1:0] == q.rptr[AW-1:0]);
        do_wr = wr_en && !full;
        do_rd = rd_en && !empty;

        d        = q;
        d.rvalid = do_rd;
        if (do_rd) begin
            d.rdata = mem[q.rptr[AW-1:0]];
            d.rptr  = q.rptr + (AW+1)'(1);
        end
        if (do_wr) d.wptr = q.wptr + (AW+1)'(1);
        if (wr_en && full) d.ovf = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (do_wr) mem[q.wptr[AW-1:0]] <= wr_data;
    end

    assign rd_data  = q.rdata;
    assign rd_valid = q.rvalid;
    assign overflow = q.ovf;

    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    // R9
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full) |=> ($stable(q.wptr) && overflow));

    // R10
    empty_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && empty) |=> (!rd_valid && $stable(q.rptr)));

    // R8
    occupancy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.wptr - q.rptr) <= (AW+1)'(DEPTH));

endmodule

// File: rtl/stream_len_tracker.sv
module stream_len_tracker
    import strk_pkg::*;
#(
    parameter int LEN_W  = 6,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 16,
    parameter int AW     = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pkt_valid,
    input  logic              pkt_first,
    input  logic              pkt_last,
    input  logic [LEN_W-1:0]  pkt_len,
    input  logic [DATA_W-1:0] pkt_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              buf_full,
    output logic              buf_empty,
    output logic              buf_overflow,
    output logic              streaming,
    output logic [CNT_W-1:0]  total_size,
    output logic [CNT_W-1:0]  accum_count
);

    logic              wr_en;
    logic [DATA_W-1:0] wr_data;

    strk_ctrl #(
        .LEN_W  (LEN_W),
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (pkt_valid),
        .in_first  (pkt_first),
        .in_last   (pkt_last),
        .in_len    (pkt_len),
        .in_data   (pkt_data),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .streaming (streaming),
        .total     (total_size),
        .accum     (accum_count)
    );

    strk_ring #(
        .AW     (AW),
        .DATA_W (DATA_W)
    ) u_ring (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_en    (rd_en),
        .rd_data  (rd_data),
        .rd_valid (rd_valid),
        .full     (buf_full),
        .empty    (buf_empty),
        .overflow (buf_overflow)
    );

endmodule

// File: tb/tb_stream_len_tracker.sv
module tb_stream_len_tracker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pkt_valid = 1'b0, pkt_first = 1'b0, pkt_last = 1'b0;
    logic [5:0]  pkt_len = '0;
    logic [7:0]  pkt_data = '0;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_data;
    logic        rd_valid, buf_full, buf_empty, buf_overflow, streaming;
    logic [15:0] total_size, accum_count;

    always #2.5 clk = ~clk;

    stream_len_tracker dut (
        .clk(clk), .rst_n(rst_n),
        .pkt_valid(pkt_valid), .pkt_first(pkt_first), .pkt_last(pkt_last),
        .pkt_len(pkt_len), .pkt_data(pkt_data),
        .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
        .buf_full(buf_full), .buf_empty(buf_empty), .buf_overflow(buf_overflow),
        .streaming(streaming), .total_size(total_size), .accum_count(accum_count)
    );

    typedef struct packed {
        logic [5:0]  len;
        logic [7:0]  b5;
        logic [7:0]  b6;
        logic        strm;
        logic [15:0] tot;
        logic [15:0] acc;
        logic        stored;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{6'd4,  8'h00, 8'h00, 1'b0, 16'd0,     16'd0,   1'b1},  // R4
        '{6'd32, 8'h00, 8'h10, 1'b1, 16'd24,    16'd32,  1'b1},  // R2 R3
        '{6'd3,  8'h00, 8'h00, 1'b0, 16'd0,     16'd0,   1'b0},  // R6
        '{6'd32, 8'h01, 8'hFF, 1'b1, 16'd263,   16'd32,  1'b1},  // R3 mask
        '{6'd32, 8'h55, 8'h00, 1'b1, 16'd263,   16'd64,  1'b1},  // R11
        '{6'd32, 8'h00, 8'h00, 1'b1, 16'd263,   16'd96,  1'b1},  // R5
        '{6'd32, 8'h00, 8'h00, 1'b1, 16'd263,   16'd128, 1'b1},
        '{6'd32, 8'h00, 8'h00, 1'b1, 16'd263,   16'd160, 1'b1},
        '{6'd32, 8'h00, 8'h00, 1'b1, 16'd263,   16'd192, 1'b1},
        '{6'd32, 8'h00, 8'h00, 1'b1, 16'd263,   16'd224, 1'b1},
        '{6'd32, 8'h00, 8'h00, 1'b1, 16'd263,   16'd256, 1'b1},
        '{6'd10, 8'h00, 8'h00, 1'b1, 16'd263,   16'd266, 1'b1},  // R5 short
        '{6'd1,  8'h00, 8'h00, 1'b0, 16'd0,     16'd0,   1'b0},  // R6
        '{6'd31, 8'h00, 8'h00, 1'b0, 16'd0,     16'd0,   1'b1},  // R4
        '{6'd32, 8'hFF, 8'hFF, 1'b1, 16'd32775, 16'd32,  1'b1}   // R3 max
    };

    int n_chk = 0, n_fail = 0;
    logic [7:0] model [4096];
    int mw = 0, mr = 0;
    bit done = 1'b0;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send_pkt(input int len, input int seed, input logic [7:0] b5,
                            input logic [7:0] b6, input bit store);
        for (int i = 0; i < len; i++) begin
            logic [7:0] v;
            v = 8'((seed + i) & 255);
            if (i == 5) v = b5;
            if (i == 6) v = b6;
            @(negedge clk);
            pkt_valid = 1'b1;
            pkt_first = (i == 0);
            pkt_last  = (i == len - 1);
            pkt_len   = 6'(len);
            pkt_data  = v;
            if (store && (mw - mr) < 2048) begin
                model[mw % 4096] = v;
                mw++;
            end
        end
        @(negedge clk);
        pkt_valid = 1'b0; pkt_first = 1'b0; pkt_last = 1'b0;
    endtask

    task automatic read_one(input string req);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        check({req, " rd_valid"}, int'(rd_valid), 1);
        check({req, " data"}, int'(rd_data), int'(model[mr % 4096]));
        mr++;
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        mw = 0; mr = 0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        check("R1 streaming", int'(streaming), 0);
        check("R1 total", int'(total_size), 0);
        check("R1 accum", int'(accum_count), 0);
        check("R1 empty", int'(buf_empty), 1);
        check("R1 full", int'(buf_full), 0);
        check("R1 overflow", int'(buf_overflow), 0);

        // vector table: R2 R3 R4 R5 R6 R11
        for (int k = 0; k < NV; k++) begin
            send_pkt(int'(VEC[k].len), k * 8, VEC[k].b5, VEC[k].b6, VEC[k].stored);
            check($sformatf("R2-6/R11 row%0d streaming", k), int'(streaming), int'(VEC[k].strm));
            check($sformatf("R3 row%0d total", k), int'(total_size), int'(VEC[k].tot));
            check($sformatf("R5 row%0d accum", k), int'(accum_count), int'(VEC[k].acc));
        end

        // R7 drain in order; R4 and R6 content shows in what was stored
        check("R7 stored count", mw, 365);
        while (mr < mw) read_one("R7");
        check("R7 empty after drain", int'(buf_empty), 1);

        // R10 read on empty
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        check("R10 rd_valid", int'(rd_valid), 0);
        check("R10 empty", int'(buf_empty), 1);

        // R1 reset clears stream state
        do_reset();
        check("R1 streaming after reset", int'(streaming), 0);
        check("R1 total after reset", int'(total_size), 0);

        // R9 fill past capacity with idle plain packets
        for (int p = 0; p < 67; p++) send_pkt(31, p * 31, 8'((p * 31 + 5) & 255),
                                               8'((p * 31 + 6) & 255), 1'b1);
        check("R9 full", int'(buf_full), 1);
        check("R9 overflow", int'(buf_overflow), 1);
        check("R9 model level", mw - mr, 2048);
        read_one("R9 first");
        check("R9 not full after read", int'(buf_full), 0);
        check("R9 overflow sticky", int'(buf_overflow), 1);
        while (mr < mw) read_one("R9");
        check("R9 empty", int'(buf_empty), 1);

        // R8 indices have wrapped; new data must read back intact
        send_pkt(20, 100, 8'd105, 8'd106, 1'b1);
        send_pkt(20, 200, 8'd205, 8'd206, 1'b1);
        check("R8 not empty", int'(buf_empty), 0);
        while (mr < mw) read_one("R8");
        check("R8 empty", int'(buf_empty), 1);
        check("R9 overflow still set", int'(buf_overflow), 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule